// File: doc/BRIEF.md
# Indirect Register Window Bridge

This bridge lets a host reach two wide internal register spaces through a handful of memory-mapped locations. Each of the two channels has three host-visible registers: an address latch, a data port and a control register. One channel leads to the top-level control register file. The other leads to the controller register file. The host talks over a simple single-cycle request port with 32-bit data. Each internal side is a plain register port with address, write data, write strobe, read strobe and read data.

Access is deliberately sequenced. The address latch has to be written twice in a row before the channel is armed. A write then needs one data-port write. A read needs two data-port reads. The first read starts the internal fetch and hands back the value captured by the previous fetch. The second read hands back the fresh value. Each finished access disarms its channel. A control bit chooses whether an out-of-sequence data access is silently dropped or answered with an error.

Top module: `iwb_top`

## Requirements
- R1: Host offsets decode on bits [4:2]. Channel A has its address latch at 0x00, its data port at 0x04 and its control register at 0x08. Channel B uses 0x10, 0x14 and 0x18. Offsets 0x0C and 0x1C read as zero, never return an error, and writes to them change nothing.
- R2: A write to an address latch keeps only bits [15:0]. Reading the latch returns those 16 bits with the upper 16 bits as zero.
- R3: A channel becomes armed only on its second consecutive address-latch write. A failed data access in between restarts the count. Further address writes keep the channel armed and replace the target address.
- R4: A data-port write on an armed channel pulses the internal write strobe for exactly one cycle, carrying the latched address and the written data. The channel is then disarmed.
- R5: The first data-port read on an armed channel pulses the internal read strobe once and returns the value captured by that channel's previous fetch (zero after reset). The second read returns the newly fetched value, pulses no strobe, and disarms the channel.
- R6: Bit 15 of each control register is the error enable. Reading a control register returns that bit in position 15 and zero in every other bit.
- R7: With the error enable set, a data access on an unarmed channel returns the error flag with zero read data and pulses no internal strobe.
- R8: With the error enable clear, a data access on an unarmed channel returns no error, reads as zero, and pulses no internal strobe.
- R9: Each channel has its own arming, fetch and error-enable state. Accesses to one channel leave the other channel's state unchanged.
- R10: Every request is answered by host_rsp exactly one cycle later. host_err is only ever high together with host_rsp.
- R11: After reset there is no response and no internal strobe, and every latch, captured value and control bit reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request valid for this cycle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 5 | Byte offset of the host register |
| host_wdata | input | 32 | Host write data |
| host_rsp | output | 1 | Response valid, one cycle after the request |
| host_rdata | output | 32 | Response read data |
| host_err | output | 1 | Error response |
| a_addr | output | 16 | Channel A internal address |
| a_wdata | output | 32 | Channel A internal write data |
| a_we | output | 1 | Channel A internal write strobe |
| a_re | output | 1 | Channel A internal read strobe |
| a_rdata | input | 32 | Channel A internal read data, valid in the strobe cycle |
| b_addr | output | 16 | Channel B internal address |
| b_wdata | output | 32 | Channel B internal write data |
| b_we | output | 1 | Channel B internal write strobe |
| b_re | output | 1 | Channel B internal read strobe |
| b_rdata | input | 32 | Channel B internal read data, valid in the strobe cycle |

## Verification
The assertions are checked on every cycle and cover the invariants of the arming machine:
- arming only ever begins right after an address write;
- a pending second read implies the channel is still armed;
- a write strobe or an error always leaves the channel disarmed;
- a response always trails its request by one cycle.

Only the bench scenarios can show the data-dependent behaviour:
- that the first read really returns the stale captured value;
- which address and data reach the internal port;
- that dropped accesses leave the internal side untouched;
- that traffic on one channel leaves the other's state unchanged.

// File: rtl/iwb_pkg.sv
package iwb_pkg;

  localparam int ERR_EN_BIT = 15;

  typedef enum logic [1:0] {
    KIND_ADDR = 2'd0,
    KIND_DATA = 2'd1,
    KIND_CTRL = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    ARM_NONE = 2'd0,
    ARM_HALF = 2'd1,
    ARM_FULL = 2'd2
  } arm_e;

  // word index inside a channel window picks the register kind
  function automatic reg_kind_e word_kind(input logic [1:0] word);
    case (word)
      2'd0:    return KIND_ADDR;
      2'd1:    return KIND_DATA;
      2'd2:    return KIND_CTRL;
      default: return KIND_NONE;
    endcase
  endfunction

  // each address-latch write advances arming by one step, saturating
  function automatic arm_e arm_step(input arm_e cur);
    case (cur)
      ARM_NONE: return ARM_HALF;
      default:  return ARM_FULL;
    endcase
  endfunction

endpackage

// File: rtl/iwb_decode.sv
module iwb_decode
  import iwb_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int HOST_AW = 5
) (
  input  logic               req,
  input  logic [HOST_AW-1:0] addr,
  output logic [NCH-1:0]     ch_sel,
  output reg_kind_e          kind
);
  localparam int CH_LSB = 4;
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1;

  logic [CH_W-1:0] ch_idx;

  always_comb begin
    ch_idx = CH_W'(addr >> CH_LSB);
    kind   = word_kind(addr[3:2]);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_sel
    assign ch_sel[c] = req && (ch_idx == CH_W'(c));
  end
endmodule

// File: rtl/iwb_chan.sv
module iwb_chan
  import iwb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel,
  input  logic               wr,
  input  reg_kind_e          kind,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err,
  output logic [IADDR_W-1:0] int_addr,
  output logic [DATA_W-1:0]  int_wdata,
  output logic               int_we,
  output logic               int_re,
  input  logic [DATA_W-1:0]  int_rdata
);
  arm_e               arm;
  logic               rd_pend;
  logic [IADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0]  hold;
  logic               err_en;

  // named internal events
  logic is_aw, is_ar, is_dw, is_dr, is_cw, is_cr;
  logic armed, bad, second_rd;

  always_comb begin
    is_aw     = sel &&  wr && (kind == KIND_ADDR);
    is_ar     = sel && !wr && (kind == KIND_ADDR);
    is_dw     = sel &&  wr && (kind == KIND_DATA);
    is_dr     = sel && !wr && (kind == KIND_DATA);
    is_cw     = sel &&  wr && (kind == KIND_CTRL);
    is_cr     = sel && !wr && (kind == KIND_CTRL);
    armed     = (arm == ARM_FULL);
    bad       = (is_dw || is_dr) && !armed;
    int_we    = is_dw && armed;
    int_re    = is_dr && armed && !rd_pend;
    second_rd = is_dr && armed && rd_pend;
    rsp_err   = bad && err_en;
    int_addr  = lat_addr;
    int_wdata = wdata;
    rsp_data  = '0;
    if (is_ar)
      rsp_data = DATA_W'(lat_addr);
    else if (is_cr)
      rsp_data[ERR_EN_BIT] = err_en;
    else if (is_dr && armed)
      rsp_data = hold;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm      <= ARM_NONE;
      rd_pend  <= 1'b0;
      lat_addr <= '0;
      hold     <= '0;
      err_en   <= 1'b0;
    end else begin
      if (is_aw) begin
        lat_addr <= wdata[IADDR_W-1:0];
        arm      <= arm_step(arm);
        rd_pend  <= 1'b0;
      end else if (int_re) begin
        hold    <= int_rdata;
        rd_pend <= 1'b1;
      end else if (int_we || second_rd || bad) begin
        arm     <= ARM_NONE;
        rd_pend <= 1'b0;
      end
      if (is_cw)
        err_en <= wdata[ERR_EN_BIT];
    end
  end

  // R3
  arm_from_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(is_aw));

  // R5
  pend_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pend |-> armed);

  // R5
  fetch_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_re |=> (rd_pend && armed));

  // R4
  write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_we |=> !armed);

  // R7
  err_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> (arm == ARM_NONE));
endmodule

// File: rtl/iwb_top.sv
module iwb_top
  import iwb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 16,
  parameter int HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic               host_rsp,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_err,
  output logic [IADDR_W-1:0] a_addr,
  output logic [DATA_W-1:0]  a_wdata,
  output logic               a_we,
  output logic               a_re,
  input  logic [DATA_W-1:0]  a_rdata,
  output logic [IADDR_W-1:0] b_addr,
  output logic [DATA_W-1:0]  b_wdata,
  output logic               b_we,
  output logic               b_re,
  input  logic [DATA_W-1:0]  b_rdata
);
  localparam int NCH = 2;

  logic [NCH-1:0]              ch_sel;
  reg_kind_e                   kind;
  logic [NCH-1:0][DATA_W-1:0]  ch_rsp_data;
  logic [NCH-1:0]              ch_rsp_err;
  logic [NCH-1:0][IADDR_W-1:0] ch_addr;
  logic [NCH-1:0][DATA_W-1:0]  ch_wdata;
  logic [NCH-1:0]              ch_we;
  logic [NCH-1:0]              ch_re;
  logic [NCH-1:0][DATA_W-1:0]  ch_rdata;
  logic [DATA_W-1:0]           rsp_data_mux;
  logic                        rsp_err_mux;

  iwb_decode #(.NCH(NCH), .HOST_AW(HOST_AW)) u_dec (
    .req    (host_req),
    .addr   (host_addr),
    .ch_sel (ch_sel),
    .kind   (kind)
  );

  assign ch_rdata[0] = a_rdata;
  assign ch_rdata[1] = b_rdata;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iwb_chan #(.DATA_W(DATA_W), .IADDR_W(IADDR_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (ch_sel[c]),
      .wr        (host_wr),
      .kind      (kind),
      .wdata     (host_wdata),
      .rsp_data  (ch_rsp_data[c]),
      .rsp_err   (ch_rsp_err[c]),
      .int_addr  (ch_addr[c]),
      .int_wdata (ch_wdata[c]),
      .int_we    (ch_we[c]),
      .int_re    (ch_re[c]),
      .int_rdata (ch_rdata[c])
    );
  end

  assign a_addr  = ch_addr[0];
  assign a_wdata = ch_wdata[0];
  assign a_we    = ch_we[0];
  assign a_re    = ch_re[0];
  assign b_addr  = ch_addr[1];
  assign b_wdata = ch_wdata[1];
  assign b_we    = ch_we[1];
  assign b_re    = ch_re[1];

  // unselected channels drive zero, so an OR merges the responses
  always_comb begin
    rsp_data_mux = '0;
    rsp_err_mux  = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      rsp_data_mux = rsp_data_mux | ch_rsp_data[c];
      rsp_err_mux  = rsp_err_mux  | ch_rsp_err[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rsp   <= 1'b0;
      host_rdata <= '0;
      host_err   <= 1'b0;
    end else begin
      host_rsp   <= host_req;
      host_rdata <= host_req ? rsp_data_mux : '0;
      host_err   <= host_req && rsp_err_mux;
    end
  end

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |=> host_rsp);

  // R10
  err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> host_rsp);
endmodule

// File: tb/tb_iwb_top.sv
module tb_iwb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rsp;
  logic [31:0] host_rdata;
  logic        host_err;
  logic [15:0] a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic        a_we, a_re, b_we, b_re;

  int n_chk = 0;
  int n_bad = 0;
  int cnt_awe = 0, cnt_are = 0, cnt_bwe = 0, cnt_bre = 0;
  logic [15:0] last_aw_addr, last_bw_addr;
  logic [31:0] last_aw_data, last_bw_data;
  logic [31:0] mem_a [0:255];
  logic [31:0] mem_b [0:255];

  always #2.5 clk = ~clk;

  iwb_top dut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rsp(host_rsp), .host_rdata(host_rdata),
    .host_err(host_err),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re), .b_rdata(b_rdata)
  );

  // register-file stand-ins
  assign a_rdata = mem_a[a_addr[7:0]];
  assign b_rdata = mem_b[b_addr[7:0]];

  always @(posedge clk) begin
    if (rst_n) begin
      if (a_we) begin
        mem_a[a_addr[7:0]] <= a_wdata;
        cnt_awe++;
        last_aw_addr <= a_addr;
        last_aw_data <= a_wdata;
      end
      if (b_we) begin
        mem_b[b_addr[7:0]] <= b_wdata;
        cnt_bwe++;
        last_bw_addr <= b_addr;
        last_bw_data <= b_wdata;
      end
      if (a_re) cnt_are++;
      if (b_re) cnt_bre++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [4:0] off, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er);
    @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = off; host_wdata = wd;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0;
    rd = host_rdata;
    er = host_err;
    if (host_rsp !== 1'b1) begin
      n_chk++; n_bad++;
      $display("FAIL R10: actual rsp %b expected 1", host_rsp);
    end
  endtask

  task automatic wr32(input logic [4:0] off, input logic [31:0] wd, output logic er);
    logic [31:0] d;
    bus(1'b1, off, wd, d, er);
  endtask

  task automatic rd32(input logic [4:0] off, output logic [31:0] d, output logic er);
    bus(1'b0, off, 32'h0, d, er);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R11 rsp idle", {31'b0, host_rsp}, 32'h0);
    chk("R11 strobes idle", {28'b0, a_we, a_re, b_we, b_re}, 32'h0);
    rd32(5'h00, d, e); chk("R11 A addr", d, 32'h0);
    rd32(5'h08, d, e); chk("R11 A ctrl", d, 32'h0);
    rd32(5'h18, d, e); chk("R11 B ctrl", d, 32'h0);
    @(negedge clk);
    chk("R10 no rsp when idle", {31'b0, host_rsp}, 32'h0);
  endtask

  task automatic t_write();
    logic [31:0] d; logic e; int w0;
    wr32(5'h00, 32'hABCD_0012, e);
    wr32(5'h00, 32'hABCD_0012, e);
    rd32(5'h00, d, e); chk("R2 addr low half", d, 32'h0000_0012);
    w0 = cnt_awe;
    wr32(5'h04, 32'h1234_5678, e);
    chk("R4 one strobe", cnt_awe, w0 + 1);
    chk("R4 addr", {16'h0, last_aw_addr}, 32'h12);
    chk("R4 data", last_aw_data, 32'h1234_5678);
    chk("R4 no err", {31'b0, e}, 32'h0);
    wr32(5'h04, 32'h5555_5555, e);
    chk("R8 unarmed write dropped", cnt_awe, w0 + 1);
    chk("R8 no err", {31'b0, e}, 32'h0);
  endtask

  task automatic t_read();
    logic [31:0] d; logic e; int r0;
    wr32(5'h00, 32'h12, e);
    wr32(5'h00, 32'h12, e);
    r0 = cnt_are;
    rd32(5'h04, d, e); chk("R5 first read stale", d, 32'h0);
    chk("R5 one fetch", cnt_are, r0 + 1);
    rd32(5'h04, d, e); chk("R5 second read fresh", d, 32'h1234_5678);
    chk("R5 no second fetch", cnt_are, r0 + 1);
    rd32(5'h04, d, e); chk("R8 disarmed read zero", d, 32'h0);
    chk("R8 disarmed no err", {31'b0, e}, 32'h0);
    chk("R8 disarmed no fetch", cnt_are, r0 + 1);
  endtask

  task automatic t_arm_seq();
    logic [31:0] d; logic e; int w0, r0;
    r0 = cnt_are; w0 = cnt_awe;
    wr32(5'h00, 32'h20, e);
    rd32(5'h04, d, e); chk("R3 one addr write not armed", cnt_are, r0);
    wr32(5'h00, 32'h20, e);
    wr32(5'h04, 32'h11, e);
    wr32(5'h00, 32'h21, e);
    wr32(5'h04, 32'h77, e);
    chk("R3 broken sequence not armed", cnt_awe, w0);
    wr32(5'h00, 32'h1, e);
    wr32(5'h00, 32'h2, e);
    wr32(5'h00, 32'h3, e);
    wr32(5'h04, 32'h99, e);
    chk("R3 third addr write stays armed", cnt_awe, w0 + 1);
    chk("R3 latest addr used", {16'h0, last_aw_addr}, 32'h3);
  endtask

  task automatic t_err();
    logic [31:0] d; logic e; int r0;
    wr32(5'h08, 32'hFFFF_FFFF, e);
    rd32(5'h08, d, e); chk("R6 ctrl only bit15", d, 32'h0000_8000);
    r0 = cnt_are;
    rd32(5'h04, d, e);
    chk("R7 unarmed read err", {31'b0, e}, 32'h1);
    chk("R7 unarmed read zero", d, 32'h0);
    chk("R7 no fetch", cnt_are, r0);
    wr32(5'h04, 32'h1, e);
    chk("R7 unarmed write err", {31'b0, e}, 32'h1);
    wr32(5'h00, 32'h3, e);
    wr32(5'h00, 32'h3, e);
    rd32(5'h04, d, e); chk("R6 armed read no err", {31'b0, e}, 32'h0);
    chk("R5 stale value from earlier fetch", d, 32'h1234_5678);
    rd32(5'h04, d, e); chk("R5 fresh after write", d, 32'h99);
    wr32(5'h08, 32'h0, e);
    rd32(5'h08, d, e); chk("R6 ctrl cleared", d, 32'h0);
  endtask

  task automatic t_indep();
    logic [31:0] d; logic e; int bw0;
    wr32(5'h08, 32'h0000_8000, e);
    wr32(5'h00, 32'h5, e);
    wr32(5'h00, 32'h5, e);
    bw0 = cnt_bwe;
    wr32(5'h10, 32'h7, e);
    wr32(5'h10, 32'h7, e);
    wr32(5'h14, 32'hCAFE, e);
    chk("R9 B write strobe", cnt_bwe, bw0 + 1);
    chk("R9 B addr", {16'h0, last_bw_addr}, 32'h7);
    chk("R9 B data", last_bw_data, 32'hCAFE);
    rd32(5'h00, d, e); chk("R9 A addr kept", d, 32'h5);
    rd32(5'h04, d, e); chk("R9 A still armed stale", d, 32'h99);
    rd32(5'h04, d, e); chk("R9 A fresh", d, 32'hA000_0005);
    rd32(5'h14, d, e); chk("R9 B err enable separate", {31'b0, e}, 32'h0);
    rd32(5'h04, d, e); chk("R9 A err enable kept", {31'b0, e}, 32'h1);
    wr32(5'h08, 32'h0, e);
  endtask

  task automatic t_map();
    logic [31:0] d; logic e;
    rd32(5'h0C, d, e);
    chk("R1 hole reads zero", d, 32'h0);
    chk("R1 hole no err", {31'b0, e}, 32'h0);
    wr32(5'h1C, 32'hFFFF_FFFF, e);
    chk("R1 hole write no err", {31'b0, e}, 32'h0);
    rd32(5'h18, d, e); chk("R1 B ctrl untouched", d, 32'h0);
    rd32(5'h10, d, e); chk("R1 B addr untouched", d, 32'h7);
    rd32(5'h14, d, e); chk("R1 B data unarmed zero", d, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_a[i] = 32'hA000_0000 | i;
      mem_b[i] = 32'hB000_0000 | i;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_arm_seq();
    t_err();
    t_indep();
    t_map();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule